// File: doc/BRIEF.md
# Multi-Core Cascaded Interrupt Router

This block is a second-level interrupt controller. It gathers 32 level-sensitive peripheral request lines and steers each one to a small set of parent request outputs on each of one or two processor cores. Every core owns a private register bank: an enable mask, a shared live status view of the lines, and four routing words. The bank is reached over a plain 32-bit memory-mapped read/write port, and a core-select input picks which bank an access goes to.

Software programs a line's routing field and its mask bit in a core's bank. From then on, the matching parent output of that core follows the line for as long as the line stays high. To find what is pending, software reads the mask and the status register and ANDs the two values. The bus port and the interrupt lines are control and status signals, so they carry no valid/ready handshake. A read is accepted in the cycle it is requested and cannot be back-pressured.

Top module: `irq_router`

## Requirements
- R1: After reset every mask bit and every routing field of every bank is zero, every bit of `parent_irq` is low, and `bus_rvalid` is low.
- R2: The mask register sits at byte offset 0x00 and can be read and written. Its bit n enables line n, and a line whose bit is clear never drives a parent output.
- R3: Offset 0x04 is read-only status. A read returns the value of `irq_in` in the cycle of the request. A write to 0x04 changes no register.
- R4: The routing words sit at offsets 0x08, 0x0C, 0x10 and 0x14 (words 0 to 3) and can be read and written. Line n has a 4-bit field in word 3 − n/8, at bits [4·(n mod 8)+3 : 4·(n mod 8)].
- R5: A routing value k from 1 to 4 sends the line to parent output k−1 of that core. The values 0 and 5 to 15 disconnect the line.
- R6: Parent output p of core c is `parent_irq[4·c + p]`. One cycle after the inputs or registers change, it equals the OR, over all lines, of (line high AND mask bit set AND field equal to p+1). It stays high while any such line stays high.
- R7: `bus_core` selects the bank. A write changes only the selected core's bank, and reads return only that bank's contents.
- R8: A read (`bus_req`=1, `bus_we`=0) gives `bus_rvalid`=1 with the data one cycle later. A write or an idle cycle gives `bus_rvalid`=0 one cycle later.
- R9: Any other offset (0x18 to 0x1F, or any offset that is not a multiple of four) reads as zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive peripheral request lines |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_core | input | CORE_W (1) | Bank select, meaning core index |
| bus_addr | input | 5 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| parent_irq | output | NUM_CORES·4 (8) | Parent requests, four per core |

## Verification
Read data and `bus_rvalid` are due one clock after the request edge. A register write takes effect at its request edge, and its effect on `parent_irq` appears one clock later. A change on `irq_in` also reaches `parent_irq` one clock later. The bench drives every stimulus on a falling edge and waits exactly one further falling edge before it samples, so every comparison lands on the first cycle the result is due. Expected outputs come from a bench-side model of the masks and routing words, evaluated with the field arithmetic given in R4 to R6.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned NUM_LINES   = 32;
  localparam int unsigned FIELD_W     = 4;
  localparam int unsigned FLD_PER_WRD = DATA_W / FIELD_W;
  localparam int unsigned ROUTE_WORDS = NUM_LINES / FLD_PER_WRD;

  localparam logic [ADDR_W-1:0] OFF_MASK   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ROUTE  = 5'h08;

  typedef logic [ROUTE_WORDS-1:0][DATA_W-1:0] route_bank_t;
endpackage

// File: rtl/irq_router_bank.sv
module irq_router_bank
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] irq_lvl,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] mask_q,
  output route_bank_t          route_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (addr == OFF_MASK) mask_q <= wdata;
      for (int w = 0; w < ROUTE_WORDS; w++) begin
        if (addr == OFF_ROUTE + ADDR_W'(4 * w)) route_q[w] <= wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == OFF_MASK)   rd_data = mask_q;
    if (addr == OFF_STATUS) rd_data = irq_lvl;
    for (int w = 0; w < ROUTE_WORDS; w++) begin
      if (addr == OFF_ROUTE + ADDR_W'(4 * w)) rd_data = route_q[w];
    end
  end
endmodule

// File: rtl/irq_router_fanin.sv
module irq_router_fanin
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PARENT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_lvl,
  input  logic [NUM_LINES-1:0]  mask,
  input  route_bank_t           route,
  output logic [NUM_PARENT-1:0] parent_q
);
  logic [NUM_PARENT-1:0][NUM_LINES-1:0] hit;
  logic [NUM_PARENT-1:0]                parent_d;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int unsigned WIDX = ROUTE_WORDS - 1 - n / FLD_PER_WRD;
    localparam int unsigned BOFF = (n % FLD_PER_WRD) * FIELD_W;
    logic [FIELD_W-1:0] fld;
    logic               live;
    assign fld  = route[WIDX][BOFF +: FIELD_W];
    assign live = irq_lvl[n] & mask[n];
    for (genvar p = 0; p < NUM_PARENT; p++) begin : g_par
      assign hit[p][n] = live & (fld == FIELD_W'(p + 1));
    end
  end

  for (genvar p = 0; p < NUM_PARENT; p++) begin : g_or
    assign parent_d[p] = |hit[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parent_q <= '0;
    else        parent_q <= parent_d;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 2,
  parameter int unsigned NUM_PARENT = 4,
  parameter int unsigned CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0]            irq_in,
  input  logic                            bus_req,
  input  logic                            bus_we,
  input  logic [CORE_W-1:0]               bus_core,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  output logic                            bus_rvalid,
  output logic [NUM_CORES*NUM_PARENT-1:0] parent_irq
);
  localparam int unsigned SEL_SLOTS = 2 ** CORE_W;

  logic [DATA_W-1:0] rd_bank [SEL_SLOTS];
  logic              rd_req;

  assign rd_req = bus_req & ~bus_we;

  for (genvar c = 0; c < SEL_SLOTS; c++) begin : g_core
    if (c < NUM_CORES) begin : g_live
      logic [NUM_LINES-1:0]  mask_q;
      route_bank_t           route_q;
      logic [NUM_PARENT-1:0] par_q;
      logic                  wr_sel;

      assign wr_sel = bus_req & bus_we & (bus_core == CORE_W'(c));

      irq_router_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_sel),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .irq_lvl (irq_in),
        .rd_data (rd_bank[c]),
        .mask_q  (mask_q),
        .route_q (route_q)
      );

      irq_router_fanin #(.NUM_PARENT(NUM_PARENT)) u_fanin (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_lvl  (irq_in),
        .mask     (mask_q),
        .route    (route_q),
        .parent_q (par_q)
      );

      assign parent_irq[c*NUM_PARENT +: NUM_PARENT] = par_q;
    end else begin : g_void
      assign rd_bank[c] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_bank[bus_core];
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 2,
  parameter int unsigned NUM_PARENT = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_LINES-1:0]            irq_in,
  input logic                            bus_req,
  input logic                            bus_we,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [DATA_W-1:0]               bus_rdata,
  input logic                            bus_rvalid,
  input logic [NUM_CORES*NUM_PARENT-1:0] parent_irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (parent_irq == '0 && !bus_rvalid));

  // R8
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R8
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R3
  status_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == OFF_STATUS) |=> (bus_rdata == $past(irq_in)));

  // R9
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && (bus_addr > 5'h14 || bus_addr[1:0] != 2'b00)) |=> (bus_rdata == '0));

  // R6
  idle_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0) |=> (parent_irq == '0));
endmodule

bind irq_router irq_router_chk #(.NUM_CORES(NUM_CORES), .NUM_PARENT(NUM_PARENT)) u_chk (.*);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  localparam int NC = 2;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [0:0]  bus_core = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NC*NP-1:0] parent_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_mask  [NC];
  logic [31:0] m_route [NC][4];

  always #2.5 clk = ~clk;

  irq_router dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC*NP-1:0] model_parent();
    logic [NC*NP-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < 32; n++)
        if (irq_in[n] && m_mask[c][n]) begin
          int f = int'((m_route[c][3 - n/8] >> (4*(n%8))) & 32'hF);
          if (f >= 1 && f <= NP) r[c*NP + f - 1] = 1'b1;
        end
    return r;
  endfunction

  task automatic wr(int c, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_core = 1'(c); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    if (a == 5'h00) m_mask[c] = d;
    if (a >= 5'h08 && a <= 5'h14 && a[1:0] == 2'b00) m_route[c][(a - 5'h08) / 4] = d;
  endtask

  task automatic rd(int c, logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_core = 1'(c); bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    check("R8 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic check_par(string req);
    @(negedge clk);
    check(req, 32'(parent_irq), 32'(model_parent()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      m_mask[c] = '0;
      for (int w = 0; w < 4; w++) m_route[c][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 parent", 32'(parent_irq), 32'd0);
    check("R1 rvalid", 32'(bus_rvalid), 32'd0);
    for (int c = 0; c < NC; c++) begin
      rd(c, 5'h00, d); check("R1 mask", d, 32'd0);
      for (int w = 0; w < 4; w++) begin
        rd(c, 5'(8 + 4*w), d); check("R1 route", d, 32'd0);
      end
    end

    // R4 R5 R6 R7: sweep every line and every field value on each core
    for (int c = 0; c < NC; c++) begin
      for (int n = 0; n < 32; n++) begin
        for (int v = 0; v < 16; v++) begin
          logic [4:0] wa = 5'(8 + 4*(3 - n/8));
          wr(c, wa, 32'(v) << (4*(n%8)));
          wr(c, 5'h00, 32'd1 << n);
          rd(c, wa, d); check("R4 route readback", d, 32'(v) << (4*(n%8)));
          irq_in = 32'd1 << n;
          check_par("R5 R6 R7 route sweep");
          irq_in = '0;
        end
      end
    end

    // R7: banks stay separate
    wr(1, 5'h00, 32'hDEAD_BEEF);
    wr(0, 5'h00, 32'h0000_1234);
    rd(1, 5'h00, d); check("R7 core1 mask", d, 32'hDEAD_BEEF);
    rd(0, 5'h00, d); check("R7 core0 mask", d, 32'h0000_1234);

    // R2: mask gating with every line routed to parent 0 of core 1
    for (int w = 0; w < 4; w++) wr(1, 5'(8 + 4*w), 32'h1111_1111);
    wr(0, 5'h00, 32'd0);
    for (int n = 0; n < 32; n++) begin
      wr(1, 5'h00, 32'd1 << n);
      irq_in = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R2 enabled line", 32'(parent_irq), 32'h10);
      irq_in = ~(32'd1 << n);
      @(negedge clk);
      check("R2 masked lines", 32'(parent_irq), 32'h00);
    end
    wr(1, 5'h00, 32'd0);
    irq_in = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R2 mask zero", 32'(parent_irq), 32'h00);

    // R6: level behaviour with two sources on parent 1 of core 0
    for (int w = 0; w < 4; w++) wr(0, 5'(8 + 4*w), 32'h2222_2222);
    wr(0, 5'h00, 32'hFFFF_FFFF);
    irq_in = (32'd1 << 3) | (32'd1 << 20);
    @(negedge clk); check("R6 two sources", 32'(parent_irq), 32'h02);
    @(negedge clk); check("R6 held", 32'(parent_irq), 32'h02);
    irq_in = 32'd1 << 20;
    @(negedge clk); check("R6 one left", 32'(parent_irq), 32'h02);
    irq_in = '0;
    @(negedge clk); check("R6 all low", 32'(parent_irq), 32'h00);

    // R3: status is live and read-only
    irq_in = 32'hA5A5_0F0F;
    rd(0, 5'h04, d); check("R3 status", d, 32'hA5A5_0F0F);
    wr(0, 5'h04, 32'h1234_5678);
    irq_in = 32'h0000_0081;
    rd(1, 5'h04, d); check("R3 status after write", d, 32'h0000_0081);
    rd(0, 5'h00, d); check("R3 mask untouched", d, m_mask[0]);
    check_par("R3 outputs");

    // R9: holes read zero and ignore writes
    for (int a = 5'h18; a < 32; a += 1) begin
      wr(0, 5'(a), 32'hFFFF_FFFF);
      rd(0, 5'(a), d); check("R9 hole", d, 32'd0);
    end
    wr(1, 5'h09, 32'hFFFF_FFFF);
    rd(1, 5'h09, d); check("R9 unaligned", d, 32'd0);
    for (int c = 0; c < NC; c++) begin
      rd(c, 5'h00, d); check("R9 mask kept", d, m_mask[c]);
      for (int w = 0; w < 4; w++) begin
        rd(c, 5'(8 + 4*w), d); check("R9 route kept", d, m_route[c][w]);
      end
    end
    check_par("R9 outputs");

    // R8: write and idle give no rvalid
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 5'h18;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    check("R8 no rvalid on write", 32'(bus_rvalid), 32'd0);
    @(negedge clk);
    check("R8 no rvalid idle", 32'(bus_rvalid), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule